// File: doc/BRIEF.md
# Shared Timer Prescaler with Selectable Count Source

This block is the common prescaler counter behind a group of three timers. It advances a free-running up-counter from one of four event sources, picked by a two-bit select field. The first source is a tick at half the system clock rate. The other three are rising edges seen on three external timer pins. Each pin passes through a two-flop synchronizer and an edge detector before it can produce a count pulse. The select value is held in a small register, and a write strobe loads it.

The counter runs while any of the three timer enables is high. When all three enables are low, it holds its value. Software can change the source only while the counter is stopped. A write that arrives while any enable is set is dropped. The count is read back through a read-only register that is wider than the counter, and the extra upper bits always read zero. A hardware reset and a software reset both return the select field to the internal source and clear the count.

Top module: `tmr_prescaler`

## Requirements
- R1: While `rst` is high, and on the first sample after it is released, `src_sel_q` is 00 and `count_q` is 0.
- R2: A one-cycle pulse on `soft_rst` clears `src_sel_q` to 00 and `count_q` to 0.
- R3: With select 00 and at least one enable high, the counter advances once every second clock. Over any 2N consecutive enabled clocks it advances by exactly N.
- R4: With select 01, 10 or 11, the counter advances by one for each rising edge of pin 0, pin 1 or pin 2 respectively. Falling edges do not count. A pin first sampled high at clock edge k shows up in `count_q` after edge k+2 and not before.
- R5: Edges on pins that are not selected leave `count_q` unchanged.
- R6: While all three bits of `timer_en` are 0, `count_q` holds its value whatever happens on the pins.
- R7: A write on `src_sel_wr` loads `src_sel_wdata` into `src_sel_q` on the next edge only when `timer_en` is 000. While any enable bit is set, the write is ignored.
- R8: The counter is CNT_W bits wide and wraps from all ones to zero.
- R9: `count_q` is REG_W bits wide. Bits CNT_W-1..0 hold the count, and every bit above them reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Synchronous active-high software reset |
| timer_en | input | 3 | Enable bits of the three timers; the counter runs while any is set |
| tmr_pin | input | 3 | Asynchronous external timer pins |
| src_sel_wr | input | 1 | Write strobe for the source select field |
| src_sel_wdata | input | 2 | Value to write: 00 half clock, 01 pin 0, 10 pin 1, 11 pin 2 |
| src_sel_q | output | 2 | Current source select field |
| count_q | output | REG_W (24) | Read-only count value, zero-extended |

## Verification
The bench builds the block with CNT_W=6 and REG_W=8. At that size a full wrap of the counter takes 128 enabled clocks on the half-rate source. This keeps the all-ones-to-zero transition, and the always-zero upper bits, inside a short run. All four select codes are swept. Each external pin is driven with slow pulse trains while the other two pins toggle at the same time. The exact three-edge latency from pin to count is checked for every pin.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    SRC_HALF = 2'b00,
    SRC_PIN0 = 2'b01,
    SRC_PIN1 = 2'b10,
    SRC_PIN2 = 2'b11
  } src_e;

  localparam int unsigned TPS_PINS = 3;
endpackage

// File: rtl/tps_edge_sync.sv
module tps_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  // STAGES synchronizer flops followed by one history flop for edge detection
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], pin};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];

  // R4: a rising edge yields a single-cycle pulse
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tps_src_mux.sv
module tps_src_mux #(
  parameter int unsigned N_PINS = 3,
  localparam int unsigned SEL_W = $clog2(N_PINS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [N_PINS-1:0] pin_rise,
  output logic              step
);
  logic half_tgl;
  logic [N_PINS:0] srcs;

  always_ff @(posedge clk) begin
    if (rst || clr) half_tgl <= 1'b0;
    else            half_tgl <= ~half_tgl;
  end

  assign srcs = {pin_rise, half_tgl};
  assign step = srcs[sel];

  // R3: the half-rate tick never fires on two consecutive clocks
  assert_half_alternates_R3: assert property (@(posedge clk) disable iff (rst || clr)
    (sel == '0 && half_tgl) |=> !half_tgl);
endmodule

// File: rtl/tps_counter.sv
module tps_counter #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (run && step) cnt <= cnt + 1'b1;
  end

  // R6: value holds while stopped
  assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (rst || clr)
    !run |=> $stable(cnt));
  // R8: all ones wraps to zero
  assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (rst || clr)
    (run && step && (&cnt)) |=> (cnt == '0));
  // R3/R4: each accepted pulse moves the count by exactly one
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst || clr)
    (run && step) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned CNT_W       = 21,
  parameter int unsigned REG_W       = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic [2:0]       timer_en,
  input  logic [2:0]       tmr_pin,
  input  logic             src_sel_wr,
  input  logic [1:0]       src_sel_wdata,
  output logic [1:0]       src_sel_q,
  output logic [REG_W-1:0] count_q
);
  import tps_pkg::*;

  localparam int unsigned PAD_W = REG_W - CNT_W;

  src_e                sel_r;
  logic [TPS_PINS-1:0] pin_rise;
  logic                step;
  logic                run;
  logic [CNT_W-1:0]    cnt;

  assign run = |timer_en;

  always_ff @(posedge clk) begin
    if (rst || soft_rst)       sel_r <= SRC_HALF;
    else if (src_sel_wr && !run) sel_r <= src_e'(src_sel_wdata);
  end

  // R7: select is frozen while any timer is enabled
  assert_sel_locked_R7: assert property (@(posedge clk) disable iff (rst || soft_rst)
    run |=> $stable(sel_r));

  for (genvar p = 0; p < TPS_PINS; p++) begin : g_pin
    tps_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst  (rst),
      .pin  (tmr_pin[p]),
      .rise (pin_rise[p])
    );
  end

  tps_src_mux #(.N_PINS(TPS_PINS)) i_mux (
    .clk      (clk),
    .rst      (rst),
    .clr      (soft_rst),
    .sel      (sel_r),
    .pin_rise (pin_rise),
    .step     (step)
  );

  tps_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (soft_rst),
    .run  (run),
    .step (step),
    .cnt  (cnt)
  );

  assign src_sel_q = sel_r;
  assign count_q   = {{PAD_W{1'b0}}, cnt};
endmodule

// File: tb/test_tmr_prescaler.sv
`timescale 1ns/1ps
module test_tmr_prescaler;
  localparam int CW = 6;
  localparam int RW = 8;
  localparam int WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          soft_rst = 1'b0;
  logic [2:0]    timer_en = 3'b000;
  logic [2:0]    tmr_pin = 3'b000;
  logic          src_sel_wr = 1'b0;
  logic [1:0]    src_sel_wdata = 2'b00;
  logic [1:0]    src_sel_q;
  logic [RW-1:0] count_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_prescaler #(.CNT_W(CW), .REG_W(RW)) i_tmr_prescaler (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .timer_en(timer_en),
    .tmr_pin(tmr_pin), .src_sel_wr(src_sel_wr), .src_sel_wdata(src_sel_wdata),
    .src_sel_q(src_sel_q), .count_q(count_q)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_sel(logic [1:0] v);
    src_sel_wdata = v; src_sel_wr = 1'b1;
    cyc(1);
    src_sel_wr = 1'b0;
  endtask

  task automatic do_soft_rst();
    soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
  endtask

  // pulse the pins in mask: 4 cycles high, 4 low
  task automatic pulse(logic [2:0] mask);
    tmr_pin = tmr_pin | mask; cyc(4);
    tmr_pin = tmr_pin & ~mask; cyc(4);
  endtask

  task automatic run_half(int pairs, logic [2:0] en);
    timer_en = en;
    cyc(2 * pairs);
    timer_en = 3'b000;
  endtask

  initial begin
    #(WD_CYCLES * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    cyc(3);
    check("R1 sel in reset", src_sel_q, 0);
    check("R1 count in reset", count_q, 0);
    rst = 1'b0;
    cyc(1);
    check("R1 sel after reset", src_sel_q, 0);
    check("R1 count after reset", count_q, 0);

    // R3: half-rate source, several lengths and enable patterns
    for (int n = 1; n <= 5; n++) begin
      base = count_q;
      run_half(n, 3'(n));
      cyc(1);
      check("R3 half-rate count", count_q, (base + n) % 64);
    end

    // R6: stopped counter holds through internal time
    base = count_q;
    cyc(10);
    check("R6 hold on half-rate", count_q, base);

    // R7: write accepted while stopped, ignored while running
    write_sel(2'b10);
    check("R7 write accepted", src_sel_q, 2);
    timer_en = 3'b100;
    write_sel(2'b01);
    check("R7 write ignored while enabled", src_sel_q, 2);
    timer_en = 3'b000;
    cyc(2);

    // R4/R5: each pin selected in turn, others toggled alongside
    for (int p = 0; p < 3; p++) begin
      write_sel(2'(p + 1));
      check("R4 sel value", src_sel_q, p + 1);
      do_soft_rst();
      write_sel(2'(p + 1));
      timer_en = 3'b001 << p;
      // latency: count visible after third edge only
      tmr_pin[p] = 1'b1;
      cyc(2);
      check("R4 no count before third edge", count_q, 0);
      cyc(1);
      check("R4 count after third edge", count_q, 1);
      cyc(3);
      tmr_pin[p] = 1'b0;
      cyc(4);
      check("R4 falling edge ignored", count_q, 1);
      for (int k = 0; k < 4; k++) pulse(3'b111);
      check("R4 pin count with neighbours active", count_q, 5);
      for (int k = 0; k < 3; k++) pulse(~(3'b001 << p));
      check("R5 unselected pins ignored", count_q, 5);
      timer_en = 3'b000;
      for (int k = 0; k < 3; k++) pulse(3'b111);
      check("R6 hold while stopped", count_q, 5);
    end

    // R2: soft reset clears select and count
    check("R2 precondition sel", src_sel_q, 3);
    do_soft_rst();
    check("R2 sel cleared", src_sel_q, 0);
    check("R2 count cleared", count_q, 0);

    // R8/R9: wrap on the half-rate source
    run_half(63, 3'b010);
    cyc(1);
    check("R9 all ones, upper bits zero", count_q, 63);
    run_half(1, 3'b010);
    cyc(1);
    check("R8 wrap to zero", count_q, 0);
    run_half(64 + 7, 3'b111);
    cyc(1);
    check("R8 full wrap plus seven", count_q, 7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule